// File: doc/BRIEF.md
# Sequential Cache-Line Prefetcher

This block sits next to a data cache and turns each demand miss into a short run of line fills to slow external memory. It fetches the missing line first, then the lines directly after it in ascending order. Each fill is a 64-byte line addressed by its line number, and memory accepts one fill at a time through a valid/ready handshake. Before it issues a prefetch fill, the block looks up the candidate line through a tag probe. Lines the cache already holds are skipped. If the line a prefetch would displace is dirty, the block raises a park strobe so that the victim goes into a writeback buffer and the prefetch still goes ahead.

There are two independent configuration choices. The trigger can be every miss, or only misses flagged as coming from a unit-stride vector memory instruction. The depth can be a fixed number of lines K, or the number of lines needed to cover a programmable multiple of the vector instruction's footprint (vector length times element size) measured from the missing address. With the multiple at one or more, a unit-stride vector access misses at most once. A run never crosses a 4 KB page. A new miss abandons whatever part of the current run has not yet been issued and starts over.

Top module: `seq_line_prefetcher`

## Requirements
- R1: After synchronous reset is released, `fill_valid` and `park_valid` are low until a miss arrives.
- R2: The cycle after `miss_valid` is sampled, `fill_valid` is high with `fill_pf` low and `fill_line` equal to `miss_addr[31:6]`. This demand fill is issued even when the probe reports the line present.
- R3: In fixed-depth mode (`cfg_len_mode`=0), a triggering miss is followed by prefetch fills (`fill_pf`=1) for the next `cfg_k` lines in ascending order.
- R4: In vector-length mode (`cfg_len_mode`=1), a triggering miss with `miss_seq`=1 prefetches every further line up to the one holding byte `miss_addr + cfg_mult*miss_vlen*2^miss_esz - 1`. A miss with `miss_seq`=0, or a footprint of zero bytes, yields the demand fill only.
- R5: With `cfg_vec_only`=1, a miss with `miss_seq`=0 yields the demand fill only, while a miss with `miss_seq`=1 triggers prefetching.
- R6: A prefetch candidate for which `probe_hit`=1 is dropped without a fill, and the next candidate is examined in the following cycle.
- R7: While `fill_valid` is high and `fill_ready` is low, the fill is held with `fill_line` and `fill_pf` unchanged, unless a new miss arrives.
- R8: A miss that arrives during a run cancels every unissued line and restarts from the new miss. A fill handshaking in that same cycle still counts as issued.
- R9: Prefetching stops at the last line of the 4 KB page that contains the miss (line index bits [5:0] = 63).
- R10: `park_valid` pulses, with `park_line` equal to `probe_victim_line`, exactly in the cycle a prefetch fill handshakes while `probe_victim_dirty`=1. Demand fills never park.
- R11: Once the last line of a run has been issued or skipped, `fill_valid` stays low until the next miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_vec_only | input | 1 | 1: only unit-stride vector misses trigger prefetch |
| cfg_len_mode | input | 1 | 1: depth follows vector footprint; 0: fixed K |
| cfg_k | input | 6 | Fixed prefetch depth in lines |
| cfg_mult | input | 4 | Footprint multiple in vector-length mode |
| miss_valid | input | 1 | Demand miss strobe |
| miss_addr | input | 32 | Byte address of the miss |
| miss_vlen | input | 7 | Vector length in elements |
| miss_esz | input | 2 | log2 of element size in bytes |
| miss_seq | input | 1 | Miss comes from a unit-stride vector instruction |
| probe_line | output | 26 | Line number being looked up in the tags |
| probe_hit | input | 1 | Probed line is present in the cache |
| probe_victim_dirty | input | 1 | Line the probed line would displace is dirty |
| probe_victim_line | input | 26 | Line number of that victim |
| fill_valid | output | 1 | Fill request valid |
| fill_line | output | 26 | Line number to fetch |
| fill_pf | output | 1 | 1: prefetch fill; 0: demand fill |
| fill_ready | input | 1 | Memory accepts the fill |
| park_valid | output | 1 | Push victim into writeback buffer |
| park_line | output | 26 | Victim line to park |

## Verification
The two functions that can collide are the handshake of an outstanding fill and the restart caused by a new miss. When both fall in one cycle, the fill counts as issued and the next cycle must already show the new demand line. The bench provokes this in two ways. It sends a second miss exactly one cycle after the first, while the idle memory model is ready, so that the demand fill handshakes in that cycle. It also sends a miss in the middle of a run while memory is busy. The reference model pops the fired line before it rebuilds its queue, and it judges every cycle of the result.

// File: rtl/pf_pkg.sv
package pf_pkg;
    localparam int ADDR_W     = 32;
    localparam int LINE_OFF_W = 6;   // 64-byte lines
    localparam int PAGE_OFF_W = 12;  // 4 KB pages
    localparam int K_W        = 6;
    localparam int MUL_W      = 4;
    localparam int VLEN_W     = 7;
    localparam int ESZ_W      = 2;

    localparam int LINE_W  = ADDR_W - LINE_OFF_W;
    localparam int IDX_W   = PAGE_OFF_W - LINE_OFF_W;
    localparam int BYTES_W = MUL_W + VLEN_W + (1 << ESZ_W) - 1;
    localparam int SPAN_W  = ((BYTES_W > PAGE_OFF_W) ? BYTES_W : PAGE_OFF_W) + 1;
    localparam int REL_W   = SPAN_W - LINE_OFF_W;

    typedef enum logic {ST_IDLE, ST_RUN} seq_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [VLEN_W-1:0] vlen;
        logic [ESZ_W-1:0]  esz;
        logic              seq;
    } miss_req_t;

    typedef struct packed {
        logic [LINE_W-1:0] line;
        logic [IDX_W-1:0]  remain;
        logic              demand;
    } cursor_t;

    function automatic logic [IDX_W-1:0] clamp_lines(input logic [REL_W-1:0] want,
                                                     input logic [IDX_W-1:0] room);
        if (want > REL_W'(room)) return room;
        return want[IDX_W-1:0];
    endfunction
endpackage

// File: rtl/pf_depth_calc.sv
module pf_depth_calc
    import pf_pkg::*;
(
    input  miss_req_t          req,
    input  logic               cfg_vec_only,
    input  logic               cfg_len_mode,
    input  logic [K_W-1:0]     cfg_k,
    input  logic [MUL_W-1:0]   cfg_mult,
    output logic [IDX_W-1:0]   count
);
    logic [BYTES_W-1:0] nbytes;
    logic [SPAN_W-1:0]  span_end;
    logic [IDX_W-1:0]   first_idx;
    logic [IDX_W-1:0]   room;
    logic [REL_W-1:0]   vl_lines;
    logic [REL_W-1:0]   want;

    always_comb begin
        nbytes    = (BYTES_W'(cfg_mult) * BYTES_W'(req.vlen)) << req.esz;
        first_idx = req.addr[PAGE_OFF_W-1:LINE_OFF_W];
        span_end  = SPAN_W'(req.addr[PAGE_OFF_W-1:0]) + SPAN_W'(nbytes) - SPAN_W'(1);
        vl_lines  = span_end[SPAN_W-1:LINE_OFF_W] - REL_W'(first_idx);
        room      = {IDX_W{1'b1}} - first_idx;

        if (cfg_vec_only && !req.seq)
            want = '0;
        else if (cfg_len_mode)
            want = (req.seq && (nbytes != '0)) ? vl_lines : '0;
        else
            want = REL_W'(cfg_k);

        count = clamp_lines(want, room);
    end
endmodule

// File: rtl/pf_sequencer.sv
module pf_sequencer
    import pf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [LINE_W-1:0] start_line,
    input  logic [IDX_W-1:0]  start_count,
    input  logic              probe_hit,
    input  logic              fill_ready,
    output logic [LINE_W-1:0] cur_line,
    output logic              fill_valid,
    output logic              fill_pf,
    output logic              fire
);
    seq_state_e state;
    cursor_t    cur;
    logic       skip;
    logic       advance;

    always_comb begin
        skip       = (state == ST_RUN) && !cur.demand && probe_hit;
        fill_valid = (state == ST_RUN) && !skip;
        fire       = fill_valid && fill_ready;
        advance    = skip || fire;
    end

    assign cur_line = cur.line;
    assign fill_pf  = !cur.demand;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cur   <= '0;
        end else if (start) begin
            state      <= ST_RUN;
            cur.line   <= start_line;
            cur.remain <= start_count;
            cur.demand <= 1'b1;
        end else if (advance) begin
            if (cur.remain == '0) begin
                state <= ST_IDLE;
            end else begin
                cur.line   <= cur.line + LINE_W'(1);
                cur.remain <= cur.remain - IDX_W'(1);
            end
            cur.demand <= 1'b0;
        end
    end
endmodule

// File: rtl/pf_park.sv
module pf_park
    import pf_pkg::*;
(
    input  logic              fire,
    input  logic              is_pf,
    input  logic              victim_dirty,
    input  logic [LINE_W-1:0] victim_line,
    output logic              park_valid,
    output logic [LINE_W-1:0] park_line
);
    always_comb begin
        park_valid = fire && is_pf && victim_dirty;
        park_line  = victim_line;
    end
endmodule

// File: rtl/seq_line_prefetcher.sv
module seq_line_prefetcher
    import pf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_vec_only,
    input  logic              cfg_len_mode,
    input  logic [K_W-1:0]    cfg_k,
    input  logic [MUL_W-1:0]  cfg_mult,
    input  logic              miss_valid,
    input  logic [ADDR_W-1:0] miss_addr,
    input  logic [VLEN_W-1:0] miss_vlen,
    input  logic [ESZ_W-1:0]  miss_esz,
    input  logic              miss_seq,
    output logic [LINE_W-1:0] probe_line,
    input  logic              probe_hit,
    input  logic              probe_victim_dirty,
    input  logic [LINE_W-1:0] probe_victim_line,
    output logic              fill_valid,
    output logic [LINE_W-1:0] fill_line,
    output logic              fill_pf,
    input  logic              fill_ready,
    output logic              park_valid,
    output logic [LINE_W-1:0] park_line
);
    miss_req_t         req;
    logic [IDX_W-1:0]  run_count;
    logic [LINE_W-1:0] cur_line;
    logic              fire;

    assign req = '{addr: miss_addr, vlen: miss_vlen, esz: miss_esz, seq: miss_seq};

    pf_depth_calc u_depth (
        .req          (req),
        .cfg_vec_only (cfg_vec_only),
        .cfg_len_mode (cfg_len_mode),
        .cfg_k        (cfg_k),
        .cfg_mult     (cfg_mult),
        .count        (run_count)
    );

    pf_sequencer u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (miss_valid),
        .start_line  (miss_addr[ADDR_W-1:LINE_OFF_W]),
        .start_count (run_count),
        .probe_hit   (probe_hit),
        .fill_ready  (fill_ready),
        .cur_line    (cur_line),
        .fill_valid  (fill_valid),
        .fill_pf     (fill_pf),
        .fire        (fire)
    );

    pf_park u_park (
        .fire         (fire),
        .is_pf        (fill_pf),
        .victim_dirty (probe_victim_dirty),
        .victim_line  (probe_victim_line),
        .park_valid   (park_valid),
        .park_line    (park_line)
    );

    assign probe_line = cur_line;
    assign fill_line  = cur_line;
endmodule

// File: rtl/pf_checker.sv
module pf_checker
    import pf_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              miss_valid,
    input logic [ADDR_W-1:0] miss_addr,
    input logic              probe_hit,
    input logic              probe_victim_dirty,
    input logic              fill_valid,
    input logic [LINE_W-1:0] fill_line,
    input logic              fill_pf,
    input logic              fill_ready,
    input logic              park_valid
);
    logic              have_last;
    logic [LINE_W-1:0] last_line;

    always_ff @(posedge clk) begin
        if (rst || miss_valid) begin
            have_last <= 1'b0;
            last_line <= '0;
        end else if (fill_valid && fill_ready) begin
            have_last <= 1'b1;
            last_line <= fill_line;
        end
    end

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!fill_valid && !park_valid));

    a_r2_demand_first: assert property (@(posedge clk) disable iff (rst)
        miss_valid |=> (fill_valid && !fill_pf &&
                        fill_line == $past(miss_addr[ADDR_W-1:LINE_OFF_W])));

    a_r7_hold_fill: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && !fill_ready && !miss_valid) |=>
            (fill_valid && $stable(fill_line) && $stable(fill_pf)));

    a_r3_ascending: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && fill_pf && have_last) |-> (fill_line > last_line));

    a_r6_no_fill_present: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && fill_pf) |-> !probe_hit);

    a_r9_in_page: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && fill_pf) |-> (fill_line[IDX_W-1:0] != '0));

    a_r10_park_only_on_pf: assert property (@(posedge clk) disable iff (rst)
        park_valid |-> (fill_valid && fill_ready && fill_pf));

    a_r10_park_when_dirty: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && fill_ready && fill_pf && probe_victim_dirty) |-> park_valid);
endmodule

bind seq_line_prefetcher pf_checker u_pf_checker (
    .clk                (clk),
    .rst                (rst),
    .miss_valid         (miss_valid),
    .miss_addr          (miss_addr),
    .probe_hit          (probe_hit),
    .probe_victim_dirty (probe_victim_dirty),
    .fill_valid         (fill_valid),
    .fill_line          (fill_line),
    .fill_pf            (fill_pf),
    .fill_ready         (fill_ready),
    .park_valid         (park_valid)
);

// File: tb/seq_line_prefetcher_bench.sv
module seq_line_prefetcher_bench;
    import pf_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic              rst;
    logic              cfg_vec_only, cfg_len_mode;
    logic [K_W-1:0]    cfg_k;
    logic [MUL_W-1:0]  cfg_mult;
    logic              miss_valid;
    logic [ADDR_W-1:0] miss_addr;
    logic [VLEN_W-1:0] miss_vlen;
    logic [ESZ_W-1:0]  miss_esz;
    logic              miss_seq;
    logic [LINE_W-1:0] probe_line;
    logic              probe_hit, probe_victim_dirty;
    logic [LINE_W-1:0] probe_victim_line;
    logic              fill_valid, fill_pf, fill_ready;
    logic [LINE_W-1:0] fill_line;
    logic              park_valid;
    logic [LINE_W-1:0] park_line;
    logic [63:0]       present_mask, dirty_mask;

    assign probe_hit          = present_mask[probe_line[5:0]];
    assign probe_victim_dirty = dirty_mask[probe_line[5:0]];
    assign probe_victim_line  = probe_line ^ 26'h100000;

    seq_line_prefetcher u_seq_line_prefetcher (.*);

    int    checks = 0;
    int    errors = 0;
    bit    done   = 0;
    string tag    = "R1";
    int    q[$];
    bit    q_dem  = 0;
    int    mem_busy = 0;

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic bit cand_present();
        return !q_dem && present_mask[q[0] & 63];
    endfunction

    task automatic compare();
        bit ev, epark;
        ev    = (q.size() > 0) && !cand_present();
        epark = ev && fill_ready && !q_dem && dirty_mask[q[0] & 63];
        chk(fill_valid === ev, "fill_valid", fill_valid, ev);
        if (ev) begin
            chk(fill_line === LINE_W'(q[0]), "fill_line", fill_line, q[0]);
            chk(fill_pf === !q_dem, "fill_pf", fill_pf, !q_dem);
        end
        chk(park_valid === epark, "park_valid", park_valid, epark);
        if (epark)
            chk(park_line === (LINE_W'(q[0]) ^ 26'h100000), "park_line",
                park_line, LINE_W'(q[0]) ^ 26'h100000);
    endtask

    // Behavioural run builder, straight from R3, R4, R5 and R9
    task automatic start_run();
        int line, n, bytes, room;
        line = int'(miss_addr >> 6);
        if (cfg_vec_only && !miss_seq) n = 0;
        else if (cfg_len_mode) begin
            bytes = int'(cfg_mult) * int'(miss_vlen) * (1 << miss_esz);
            n = (miss_seq && bytes != 0) ? (int'((miss_addr + bytes - 1) >> 6) - line) : 0;
        end else n = int'(cfg_k);
        room = 63 - (line % 64);
        if (n > room) n = room;
        q = {};
        for (int i = 0; i <= n; i++) q.push_back(line + i);
        q_dem = 1;
    endtask

    task automatic model_step();
        bit fired = 0;
        if (q.size() > 0) begin
            if (cand_present()) begin
                void'(q.pop_front()); q_dem = 0;
            end else if (fill_ready) begin
                void'(q.pop_front()); q_dem = 0; fired = 1;
            end
        end
        if (miss_valid) start_run();
        if (fired) mem_busy = 8;
        else if (mem_busy > 0) mem_busy--;
        fill_ready = (mem_busy == 0);
    endtask

    task automatic tick();
        @(negedge clk); #2;
        compare();
        @(posedge clk); #1;
        model_step();
        miss_valid = 1'b0;
    endtask

    task automatic miss(input logic [31:0] a, input int vl, input int esz, input bit seq);
        miss_addr  = a;
        miss_vlen  = VLEN_W'(vl);
        miss_esz   = ESZ_W'(esz);
        miss_seq   = seq;
        miss_valid = 1'b1;
        tick();
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 400 && (q.size() != 0 || mem_busy != 0); i++) tick();
        tick();
    endtask

    initial begin
        rst = 1'b1; miss_valid = 0; miss_addr = 0; miss_vlen = 0; miss_esz = 0; miss_seq = 0;
        cfg_vec_only = 0; cfg_len_mode = 0; cfg_k = 6'd3; cfg_mult = 4'd1;
        present_mask = '0; dirty_mask = '0; fill_ready = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        tag = "R1"; tick(); tick();

        tag = "R3"; miss(32'h0000_1140, 0, 0, 0); wait_idle();           // lines 0x45..0x48

        tag = "R2"; present_mask = 64'h1 << 5;                           // demand line marked present
        miss(32'h0000_1140, 0, 0, 0); wait_idle(); present_mask = '0;

        tag = "R5"; cfg_vec_only = 1;
        miss(32'h0000_2000, 8, 2, 0); wait_idle();                       // demand only
        miss(32'h0000_2400, 8, 2, 1); wait_idle();                       // K lines follow
        cfg_vec_only = 0;

        tag = "R4"; cfg_len_mode = 1; cfg_mult = 4'd2;
        miss(32'h0000_2010, 16, 2, 1); wait_idle();                      // 128 B -> 2 prefetches
        miss(32'h0000_2010, 16, 2, 0); wait_idle();                      // non-sequential: none
        cfg_mult = 4'd1; miss(32'h0000_3000, 64, 2, 1); wait_idle();     // 256 B -> 3 prefetches
        miss(32'h0000_3000, 0, 2, 1); wait_idle();                       // empty footprint
        cfg_mult = 4'd8; miss(32'h0000_3020, 5, 1, 1); wait_idle();      // 80 B, unaligned
        cfg_len_mode = 0;

        tag = "R6"; cfg_k = 6'd5; present_mask = (64'h1 << 2) | (64'h1 << 3);
        miss(32'h0000_0040, 0, 0, 0); wait_idle(); present_mask = '0;

        tag = "R9"; miss(32'h0000_0F80, 0, 0, 0); wait_idle();           // idx 62: one prefetch
        miss(32'h0000_0FC0, 0, 0, 0); wait_idle();                       // idx 63: none
        cfg_len_mode = 1; cfg_mult = 4'd15;
        miss(32'h0000_4F00, 64, 2, 1); wait_idle();                      // footprint past page end
        cfg_len_mode = 0;

        tag = "R10"; cfg_k = 6'd2; dirty_mask = (64'h1 << 9) | (64'h1 << 10) | (64'h1 << 11);
        miss(32'h0000_0240, 0, 0, 0); wait_idle(); dirty_mask = '0;

        tag = "R7"; cfg_k = 6'd2; miss(32'h0000_8000, 0, 0, 0); wait_idle();

        tag = "R8"; cfg_k = 6'd4;
        miss(32'h0000_5000, 0, 0, 0);
        miss(32'h0000_6000, 0, 0, 0);                                    // coincides with demand fire
        repeat (12) tick();
        miss(32'h0000_7000, 0, 0, 0);                                    // mid-run, memory busy
        wait_idle();

        tag = "R11"; repeat (6) tick();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule